// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block turns a virtual address into a physical address by searching every stored translation at once. A virtual address splits into a virtual page number (upper bits) and a page offset (lower bits). When a valid entry holds a matching page number, the entry's physical page number is joined with the unchanged offset to form the physical address. If no entry matches, the block reports a miss and gives no translation. An external page walker or software then loads the missing entry through the refill port.

Each entry also holds a read permission and a write permission. A hit whose access type is not permitted raises a fault instead of a translation. The hardware keeps a use bit and a dirty bit for every entry. Software can read these bits through a status index, clear all use bits at once and clear one entry's dirty bit. Clearing the use bits now and then gives an approximate least-recently-used view of the pages. The refill port uses these bits to pick the entry it replaces.

Top module: `tlb_xlate`

## Requirements
- R1: The virtual address is VA_W = VPN_W + OFS_W bits wide, with the page number in bits [VA_W-1:OFS_W]. The physical address is {physical page number, offset}, PPN_W + OFS_W bits wide (defaults 36, 12 and 33, which give 48-bit virtual and 45-bit physical addresses).
- R2: On a permitted hit, paddr[OFS_W-1:0] equals lk_vaddr[OFS_W-1:0] in the same cycle.
- R3: Lookup is combinational and fully associative. With lk_req high, any valid entry whose page number matches gives hit=1; otherwise miss=1, xl_valid=0 and paddr=0. With lk_req low, hit, miss, fault and xl_valid are all 0.
- R4: A load (lk_store=0) needs the entry's read permission, and a store (lk_store=1) needs its write permission. A hit without the needed permission gives fault=1, xl_valid=0 and paddr=0.
- R5: Every hit, including one that faults, sets that entry's use bit at the clock edge that ends the lookup cycle.
- R6: A permitted store hit sets the entry's dirty bit at the same edge. Loads and faulting stores leave the dirty bit unchanged.
- R7: st_idx selects an entry whose valid, use and dirty bits appear combinationally on st_valid, st_use and st_dirty. A sw_clr_use pulse clears every use bit, except that a hit in the same cycle still sets its own. A sw_clr_dirty pulse clears the dirty bit of entry st_idx.
- R8: A refill writes at the next clock edge. It goes into the lowest-numbered invalid entry; if there is none, into the lowest entry with its use bit clear; otherwise into entry 0. The written entry becomes valid with its use and dirty bits clear.
- R9: A flush pulse clears every valid bit at one clock edge. A refill in the same cycle is dropped.
- R10: After reset every entry is invalid, with its use and dirty bits clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_store | input | 1 | Access type: 1 store, 0 load |
| lk_vaddr | input | VPN_W+OFS_W | Virtual address to translate |
| hit | output | 1 | A valid entry matched |
| miss | output | 1 | Request with no matching entry |
| fault | output | 1 | Hit lacking the needed permission |
| xl_valid | output | 1 | Translation valid and permitted |
| paddr | output | PPN_W+OFS_W | Translated physical address |
| rf_we | input | 1 | Refill write strobe |
| rf_vpn | input | VPN_W | Refill virtual page number |
| rf_ppn | input | PPN_W | Refill physical page number |
| rf_rd_ok | input | 1 | Refill read permission |
| rf_wr_ok | input | 1 | Refill write permission |
| flush | input | 1 | Invalidate all entries |
| st_idx | input | $clog2(ENTRIES) | Status entry select |
| st_valid | output | 1 | Valid bit of selected entry |
| st_use | output | 1 | Use bit of selected entry |
| st_dirty | output | 1 | Dirty bit of selected entry |
| sw_clr_use | input | 1 | Clear all use bits |
| sw_clr_dirty | input | 1 | Clear dirty bit of entry st_idx |

## Verification
The bench builds the block with ENTRIES=4 and keeps the default address widths. With only four entries, the bench can fill the buffer within a few refills. That brings into reach all three victim-choice branches: a free entry, a clear use bit, and the fallback to entry 0. Keeping the full 36-bit and 33-bit page fields means that tags and physical pages with their top bits set are carried through without truncation.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
   typedef enum logic {
      ACC_LOAD  = 1'b0,
      ACC_STORE = 1'b1
   } acc_e;

   localparam int unsigned DEF_ENTRIES = 64;
   localparam int unsigned DEF_VPN_W   = 36;
   localparam int unsigned DEF_PPN_W   = 33;
   localparam int unsigned DEF_OFS_W   = 12;
endpackage

// File: rtl/tlb_first_set.sv
// Lowest-index set bit finder.
module tlb_first_set #(
   parameter int unsigned N     = 4,
   parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     vec,
   output logic             found,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) begin
            found = 1'b1;
            idx   = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/tlb_entry_array.sv
// Entry storage, tag compare and status bit maintenance.
module tlb_entry_array #(
   parameter int unsigned ENTRIES = 64,
   parameter int unsigned VPN_W   = 36,
   parameter int unsigned PPN_W   = 33,
   parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [VPN_W-1:0]   cmp_vpn,
   output logic [ENTRIES-1:0] match,
   output logic [ENTRIES-1:0] valid_v,
   output logic [ENTRIES-1:0] use_v,
   output logic [ENTRIES-1:0] dirty_v,
   output logic [ENTRIES-1:0] rd_ok_v,
   output logic [ENTRIES-1:0] wr_ok_v,
   output logic [PPN_W-1:0]   ppn_a [ENTRIES],
   input  logic               inv_all,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [VPN_W-1:0]   wr_vpn,
   input  logic [PPN_W-1:0]   wr_ppn,
   input  logic               wr_rd_ok,
   input  logic               wr_wr_ok,
   input  logic               ref_en,
   input  logic               mark_dirty,
   input  logic [IDX_W-1:0]   ref_idx,
   input  logic               clr_use_all,
   input  logic               clr_dirty,
   input  logic [IDX_W-1:0]   clr_dirty_idx
);
   logic [VPN_W-1:0] vpn_a [ENTRIES];

   for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      logic sel_wr, sel_ref, sel_clr;
      assign sel_wr  = wr_en && (wr_idx == IDX_W'(g));
      assign sel_ref = ref_en && (ref_idx == IDX_W'(g));
      assign sel_clr = clr_dirty && (clr_dirty_idx == IDX_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            valid_v[g] <= 1'b0;
            use_v[g]   <= 1'b0;
            dirty_v[g] <= 1'b0;
         end else if (inv_all) begin
            valid_v[g] <= 1'b0;
            use_v[g]   <= 1'b0;
            dirty_v[g] <= 1'b0;
         end else if (sel_wr) begin
            valid_v[g] <= 1'b1;
            use_v[g]   <= 1'b0;
            dirty_v[g] <= 1'b0;
         end else begin
            use_v[g]   <= (use_v[g] & ~clr_use_all) | sel_ref;
            dirty_v[g] <= (dirty_v[g] & ~sel_clr) | (sel_ref & mark_dirty);
         end
      end

      always_ff @(posedge clk) begin
         if (!inv_all && sel_wr) begin
            vpn_a[g]   <= wr_vpn;
            ppn_a[g]   <= wr_ppn;
            rd_ok_v[g] <= wr_rd_ok;
            wr_ok_v[g] <= wr_wr_ok;
         end
      end

      assign match[g] = valid_v[g] && (vpn_a[g] == cmp_vpn);
   end
endmodule

// File: rtl/tlb_victim_pick.sv
// Refill slot choice: free entry, then unreferenced entry, then entry 0.
module tlb_victim_pick #(
   parameter int unsigned ENTRIES = 64,
   parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
   input  logic [ENTRIES-1:0] valid_v,
   input  logic [ENTRIES-1:0] use_v,
   output logic [IDX_W-1:0]   victim
);
   logic             free_found, cold_found;
   logic [IDX_W-1:0] free_idx, cold_idx;

   tlb_first_set #(.N(ENTRIES), .IDX_W(IDX_W)) u_free (
      .vec(~valid_v), .found(free_found), .idx(free_idx));
   tlb_first_set #(.N(ENTRIES), .IDX_W(IDX_W)) u_cold (
      .vec(~use_v), .found(cold_found), .idx(cold_idx));

   always_comb begin
      if (free_found)      victim = free_idx;
      else if (cold_found) victim = cold_idx;
      else                 victim = '0;
   end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
   import tlb_pkg::*;
#(
   parameter int unsigned ENTRIES = DEF_ENTRIES,
   parameter int unsigned VPN_W   = DEF_VPN_W,
   parameter int unsigned PPN_W   = DEF_PPN_W,
   parameter int unsigned OFS_W   = DEF_OFS_W,
   localparam int unsigned IDX_W  = $clog2(ENTRIES),
   localparam int unsigned VA_W   = VPN_W + OFS_W,
   localparam int unsigned PA_W   = PPN_W + OFS_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lk_req,
   input  logic             lk_store,
   input  logic [VA_W-1:0]  lk_vaddr,
   output logic             hit,
   output logic             miss,
   output logic             fault,
   output logic             xl_valid,
   output logic [PA_W-1:0]  paddr,
   input  logic             rf_we,
   input  logic [VPN_W-1:0] rf_vpn,
   input  logic [PPN_W-1:0] rf_ppn,
   input  logic             rf_rd_ok,
   input  logic             rf_wr_ok,
   input  logic             flush,
   input  logic [IDX_W-1:0] st_idx,
   output logic             st_valid,
   output logic             st_use,
   output logic             st_dirty,
   input  logic             sw_clr_use,
   input  logic             sw_clr_dirty
);
   if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_entries
      $error("tlb_xlate: ENTRIES must be a power of two of at least 2");
   end
   if (VPN_W < 1 || PPN_W < 1 || OFS_W < 1) begin : g_bad_widths
      $error("tlb_xlate: field widths must be positive");
   end

   logic [VPN_W-1:0]   cur_vpn;
   logic [OFS_W-1:0]   cur_ofs;
   logic [ENTRIES-1:0] match, valid_v, use_v, dirty_v, rd_ok_v, wr_ok_v;
   logic [PPN_W-1:0]   ppn_a [ENTRIES];
   logic               any_match, perm_ok;
   logic [IDX_W-1:0]   hit_idx, victim;
   acc_e               acc;

   assign cur_vpn = lk_vaddr[VA_W-1:OFS_W];
   assign cur_ofs = lk_vaddr[OFS_W-1:0];
   assign acc     = acc_e'(lk_store);

   tlb_entry_array #(
      .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .IDX_W(IDX_W)
   ) u_arr (
      .clk(clk), .rst_n(rst_n), .cmp_vpn(cur_vpn),
      .match(match), .valid_v(valid_v), .use_v(use_v), .dirty_v(dirty_v),
      .rd_ok_v(rd_ok_v), .wr_ok_v(wr_ok_v), .ppn_a(ppn_a),
      .inv_all(flush), .wr_en(rf_we), .wr_idx(victim),
      .wr_vpn(rf_vpn), .wr_ppn(rf_ppn), .wr_rd_ok(rf_rd_ok), .wr_wr_ok(rf_wr_ok),
      .ref_en(hit), .mark_dirty(xl_valid && acc == ACC_STORE), .ref_idx(hit_idx),
      .clr_use_all(sw_clr_use), .clr_dirty(sw_clr_dirty), .clr_dirty_idx(st_idx)
   );

   tlb_first_set #(.N(ENTRIES), .IDX_W(IDX_W)) u_hit_enc (
      .vec(match), .found(any_match), .idx(hit_idx));

   tlb_victim_pick #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
      .valid_v(valid_v), .use_v(use_v), .victim(victim));

   always_comb begin
      perm_ok  = (acc == ACC_STORE) ? wr_ok_v[hit_idx] : rd_ok_v[hit_idx];
      hit      = lk_req && any_match;
      miss     = lk_req && !any_match;
      fault    = hit && !perm_ok;
      xl_valid = hit && perm_ok;
      paddr    = xl_valid ? {ppn_a[hit_idx], cur_ofs} : '0;
   end

   assign st_valid = valid_v[st_idx];
   assign st_use   = use_v[st_idx];
   assign st_dirty = dirty_v[st_idx];
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
   parameter int unsigned VA_W  = 48,
   parameter int unsigned PA_W  = 45,
   parameter int unsigned OFS_W = 12
) (
   input logic            clk,
   input logic            rst_n,
   input logic            lk_req,
   input logic [VA_W-1:0] lk_vaddr,
   input logic            hit,
   input logic            miss,
   input logic            fault,
   input logic            xl_valid,
   input logic [PA_W-1:0] paddr,
   input logic            flush
);
   AST_OFS_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
      xl_valid |-> paddr[OFS_W-1:0] == lk_vaddr[OFS_W-1:0]); // R2
   AST_HIT_XOR_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      lk_req |-> (hit ^ miss)); // R3
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_req |-> !hit && !miss && !fault && !xl_valid); // R3
   AST_MISS_NO_XLATE: assert property (@(posedge clk) disable iff (!rst_n)
      miss |-> !xl_valid && paddr == '0); // R3
   AST_FAULT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> !xl_valid && hit && paddr == '0); // R4
   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(flush) && $past(rst_n)) |-> !hit); // R9
endmodule

bind tlb_xlate tlb_xlate_chk #(.VA_W(VA_W), .PA_W(PA_W), .OFS_W(OFS_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vaddr(lk_vaddr), .hit(hit),
   .miss(miss), .fault(fault), .xl_valid(xl_valid), .paddr(paddr), .flush(flush));

// File: tb/sim_tlb_xlate.sv
`timescale 1ns/1ps
module sim_tlb_xlate;
   localparam int ENT = 4, VW = 36, PW = 33, OW = 12, IW = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic lk_req = 0, lk_store = 0;
   logic [VW+OW-1:0] lk_vaddr = '0;
   logic hit, miss, fault, xl_valid;
   logic [PW+OW-1:0] paddr;
   logic rf_we = 0, rf_rd_ok = 0, rf_wr_ok = 0, flush = 0;
   logic [VW-1:0] rf_vpn = '0;
   logic [PW-1:0] rf_ppn = '0;
   logic [IW-1:0] st_idx = '0;
   logic st_valid, st_use, st_dirty, sw_clr_use = 0, sw_clr_dirty = 0;

   int n_chk = 0, n_bad = 0;
   logic r_hit, r_miss, r_fault, r_xl;
   logic [PW+OW-1:0] r_pa;

   always #5 clk = ~clk;

   tlb_xlate #(.ENTRIES(ENT), .VPN_W(VW), .PPN_W(PW), .OFS_W(OW)) u0 (.*);

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic lookup(logic [VW-1:0] vpn, logic [OW-1:0] ofs, logic st);
      @(negedge clk);
      lk_req = 1; lk_store = st; lk_vaddr = {vpn, ofs};
      #1;
      r_hit = hit; r_miss = miss; r_fault = fault; r_xl = xl_valid; r_pa = paddr;
      @(negedge clk);
      lk_req = 0; lk_store = 0;
   endtask

   task automatic refill(logic [VW-1:0] vpn, logic [PW-1:0] ppn, logic rd, logic wr);
      @(negedge clk);
      rf_we = 1; rf_vpn = vpn; rf_ppn = ppn; rf_rd_ok = rd; rf_wr_ok = wr;
      @(negedge clk);
      rf_we = 0;
   endtask

   task automatic status(int idx);
      st_idx = IW'(idx);
      #1;
   endtask

   localparam logic [VW-1:0] VA = 36'h123456789, VB = 36'hFFFFFFFFF, VC = 36'h000000ABC,
                             VD = 36'h800000001, VE = 36'h5A5A5A5A5, VF = 36'h0F0F0F0F0;
   localparam logic [PW-1:0] PA = 33'h1ABCDEF01, PB = 33'h000000123, PC = 33'h100000000;

   task automatic t_reset();
      #1;
      check("R10 hit idle", hit, 0); check("R10 xl idle", xl_valid, 0);
      for (int i = 0; i < ENT; i++) begin
         status(i);
         check("R10 valid", st_valid, 0); check("R10 use", st_use, 0);
         check("R10 dirty", st_dirty, 0);
      end
      lookup(VA, 12'h000, 0);
      check("R3 miss after reset", r_miss, 1); check("R3 no xl", r_xl, 0);
   endtask

   task automatic t_hit();
      refill(VA, PA, 1, 1);
      lookup(VA, 12'hABC, 0);
      check("R3 hit", r_hit, 1); check("R3 xl", r_xl, 1); check("R4 no fault", r_fault, 0);
      check("R1 R2 paddr", r_pa, {PA, 12'hABC});
      status(0);
      check("R5 use set", st_use, 1); check("R6 load no dirty", st_dirty, 0);
      lookup(VA, 12'hFFF, 1);
      check("R2 store paddr", r_pa, {PA, 12'hFFF});
      status(0); check("R6 store dirty", st_dirty, 1);
      lookup(VB, 12'h123, 0);
      check("R3 miss", r_miss, 1); check("R3 miss hit", r_hit, 0);
      check("R3 miss paddr", r_pa, 0); check("R3 miss xl", r_xl, 0);
   endtask

   task automatic t_perm();
      refill(VB, PB, 1, 0);
      lookup(VB, 12'h010, 1);
      check("R4 store fault", r_fault, 1); check("R4 fault xl", r_xl, 0);
      check("R4 fault hit", r_hit, 1); check("R4 fault paddr", r_pa, 0);
      status(1);
      check("R5 use on fault", st_use, 1); check("R6 no dirty on fault", st_dirty, 0);
      lookup(VB, 12'h010, 0);
      check("R4 load ok", r_xl, 1); check("R4 load paddr", r_pa, {PB, 12'h010});
      refill(VC, PC, 0, 1);
      lookup(VC, 12'h7FF, 0);
      check("R4 load fault", r_fault, 1);
      lookup(VC, 12'h7FF, 1);
      check("R4 store ok", r_xl, 1); check("R4 store paddr", r_pa, {PC, 12'h7FF});
   endtask

   task automatic t_sw();
      @(negedge clk);
      sw_clr_use = 1; lk_req = 1; lk_store = 0; lk_vaddr = {VB, 12'h0};
      @(negedge clk);
      sw_clr_use = 0; lk_req = 0;
      status(0); check("R7 use cleared", st_use, 0);
      status(1); check("R7 hit beats clear", st_use, 1);
      status(0);
      @(negedge clk); sw_clr_dirty = 1;
      @(negedge clk); sw_clr_dirty = 0;
      #1; check("R7 dirty cleared", st_dirty, 0);
      status(2); check("R7 other dirty kept", st_dirty, 1);
   endtask

   task automatic t_flush();
      @(negedge clk); flush = 1;
      @(negedge clk); flush = 0;
      lookup(VA, 12'h1, 0); check("R9 miss after flush", r_miss, 1);
      status(0); check("R9 invalid", st_valid, 0);
      @(negedge clk); flush = 1; rf_we = 1; rf_vpn = VD; rf_ppn = PB; rf_rd_ok = 1;
      @(negedge clk); flush = 0; rf_we = 0;
      lookup(VD, 12'h1, 0); check("R9 refill dropped", r_miss, 1);
      status(0); check("R9 still invalid", st_valid, 0);
   endtask

   task automatic t_victim();
      refill(VA, PA, 1, 1); refill(VB, PB, 1, 1);
      refill(VC, PC, 1, 1); refill(VD, PA, 1, 1);
      for (int i = 0; i < ENT; i++) begin
         status(i); check("R8 fill valid", st_valid, 1); check("R8 fill use clear", st_use, 0);
      end
      lookup(VA, 12'h0, 0); lookup(VB, 12'h0, 0);
      refill(VE, PB, 1, 1);
      status(2); check("R8 cold slot use", st_use, 0);
      lookup(VC, 12'h0, 0); check("R8 cold victim replaced", r_miss, 1);
      lookup(VE, 12'h5, 0); check("R8 new entry", r_pa, {PB, 12'h5});
      lookup(VD, 12'h0, 0); check("R8 keep D", r_hit, 1);
      refill(VF, PC, 1, 1);
      status(0); check("R8 slot0 refilled use", st_use, 0);
      lookup(VA, 12'h0, 0); check("R8 entry0 fallback", r_miss, 1);
      lookup(VF, 12'h9, 0); check("R8 F hits", r_pa, {PC, 12'h9});
      lookup(VB, 12'h0, 0); check("R8 B kept", r_hit, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset(); t_hit(); t_perm(); t_sw(); t_flush(); t_victim();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #200000;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule